// File: doc/BRIEF.md
# Sorted Release-Time Timer Queue

This block holds postponed task requests. Each request names a task and gives a 32-bit absolute release time. Requests are kept in a queue sorted by release time. A controller compares the head of the queue with a 32-bit free-running time base. When the head's release time has been reached, the controller raises a one-cycle pend strobe that carries the task identifier, then removes the head.

When the head is still in the future, the controller computes a reload value for an external 24-bit down-counting wake-up timer and strobes it out. That timer is much narrower than the time base. A distant deadline is therefore reached by re-arming the timer at its maximum on each wake-up interrupt until the remaining time fits.

The controller runs an evaluation in three cases: when a newly accepted request becomes the head, when a wake-up interrupt arrives while work is queued, and directly after each release. Releases continue one per cycle until the queue is empty or the head is not yet due. Each task may have at most one request outstanding, so the queue depth equals the number of tasks.

Top module: `release_timer_queue`

## Requirements
- R1: After reset the queue is empty and pend_valid, tmr_load and enq_err are all 0.
- R2: Entries leave in ascending order of release time, where a is earlier than b when the signed 32-bit value (a - b) is negative. Entries with equal release times leave in the order they were accepted.
- R3: An accepted request that becomes the head is evaluated on the next clock edge. Its outcome (pend or load) is visible in the cycle after that edge.
- R4: When an evaluated head has remaining time (release - now, signed 32 bit) of zero or less, pend_valid is 1 for one cycle with pend_task set to its task id. That entry is removed, and the new head is evaluated on the following edge. At most one of pend_valid and tmr_load is 1 in any cycle.
- R5: With the queue empty (idle), wake_irq has no effect on pend_valid or tmr_load. With entries queued (waiting), wake_irq causes the head to be evaluated on the next edge.
- R6: When an evaluated head has remaining time greater than 0, tmr_load is 1 for one cycle. tmr_value is 2^24-1 (0xFFFFFF) if the remaining time exceeds that value, and remaining time minus 1 otherwise.
- R7: The queue holds up to NUM_TASKS entries, one per task id.
- R8: A request for a task id already queued, or a request arriving while the queue is full, is dropped. enq_err is 1 for exactly the cycle after such a request.
- R9: When a release and a request occur in the same cycle, the release is applied first. The released task may therefore be requested again in that cycle without error.
- R10: Remaining time is computed modulo 2^32, so a release time that lies just past a wrap of the time base is treated as being in the future.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Request strobe |
| enq_task | input | TID_W | Task id of the request |
| enq_time | input | 32 | Absolute release time of the request |
| now | input | 32 | Free-running time base |
| wake_irq | input | 1 | Wake-up timer interrupt |
| pend_valid | output | 1 | One-cycle release strobe |
| pend_task | output | TID_W | Released task id |
| tmr_load | output | 1 | One-cycle wake-up timer load strobe |
| tmr_value | output | 24 | Wake-up timer reload value |
| enq_err | output | 1 | Rejected request flag |

## Verification
The release of a due head and the acceptance of a new request can fall in the same cycle. If they do, the slot freed by the release has to be counted before the duplicate and full checks are made. A directed case pulses wake_irq so that a due head is evaluated, and on that exact edge requests the same task again. The bench then expects the pend strobe, no error, and a fresh reload computed from the new request's release time. The random phase keeps provoking the overlap, and a cycle-accurate reference model judges every cycle.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
  localparam int TIME_W = 32;
  localparam int WAKE_W = 24;
  localparam logic [WAKE_W-1:0] WAKE_MAX = '1;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} hstate_e;

  // signed distance from cur to rel, wrap-safe
  function automatic logic signed [TIME_W-1:0] time_left(input logic [TIME_W-1:0] rel,
                                                         input logic [TIME_W-1:0] cur);
    return $signed(rel - cur);
  endfunction

  // a strictly later than b
  function automatic logic runs_after(input logic [TIME_W-1:0] a, input logic [TIME_W-1:0] b);
    return time_left(a, b) > 0;
  endfunction

  // reload for the narrow down counter, left > 0 assumed
  function automatic logic [WAKE_W-1:0] wake_reload(input logic signed [TIME_W-1:0] left);
    logic [TIME_W-1:0] m1;
    if (left > $signed({{(TIME_W-WAKE_W){1'b0}}, WAKE_MAX})) return WAKE_MAX;
    m1 = left - 1;
    return m1[WAKE_W-1:0];
  endfunction
endpackage

// File: rtl/rtq_order_queue.sv
module rtq_order_queue
  import rtq_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int TID_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              enq_valid_i,
  input  logic [TID_W-1:0]  enq_task_i,
  input  logic [TIME_W-1:0] enq_time_i,
  output logic [TID_W-1:0]  head_task_o,
  output logic [TIME_W-1:0] head_time_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_next_o,
  output logic              enq_head_o,
  output logic              enq_err_o
);
  logic [TID_W-1:0]  q_tid [NUM_TASKS];
  logic [TIME_W-1:0] q_tim [NUM_TASKS];
  logic [TID_W-1:0]  b_tid [NUM_TASKS];
  logic [TIME_W-1:0] b_tim [NUM_TASKS];
  logic [TID_W-1:0]  n_tid [NUM_TASKS];
  logic [TIME_W-1:0] n_tim [NUM_TASKS];
  logic [NUM_TASKS-1:0] not_later, dup;
  logic [CNT_W-1:0] count, b_cnt, ins_pos;
  logic full, accept;

  // view of the queue after the head is taken
  assign b_cnt = count - CNT_W'(pop_i);

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_base
    if (i < NUM_TASKS - 1) begin : g_mid
      assign b_tid[i] = pop_i ? q_tid[i+1] : q_tid[i];
      assign b_tim[i] = pop_i ? q_tim[i+1] : q_tim[i];
    end else begin : g_last
      assign b_tid[i] = pop_i ? '0 : q_tid[i];
      assign b_tim[i] = pop_i ? '0 : q_tim[i];
    end
    assign not_later[i] = (CNT_W'(i) < b_cnt) && !runs_after(b_tim[i], enq_time_i);
    assign dup[i]       = (CNT_W'(i) < b_cnt) && (b_tid[i] == enq_task_i);
  end

  assign ins_pos = CNT_W'($countones(not_later));
  assign full    = (b_cnt == CNT_W'(NUM_TASKS));
  assign accept  = enq_valid_i && !full && !(|dup);

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_ins
    if (i == 0) begin : g_first
      assign n_tid[i] = (accept && ins_pos == '0) ? enq_task_i : b_tid[i];
      assign n_tim[i] = (accept && ins_pos == '0) ? enq_time_i : b_tim[i];
    end else begin : g_rest
      always_comb begin
        if (!accept || CNT_W'(i) < ins_pos) begin
          n_tid[i] = b_tid[i];
          n_tim[i] = b_tim[i];
        end else if (CNT_W'(i) == ins_pos) begin
          n_tid[i] = enq_task_i;
          n_tim[i] = enq_time_i;
        end else begin
          n_tid[i] = b_tid[i-1];
          n_tim[i] = b_tim[i-1];
        end
      end
    end
  end

  assign count_next_o = b_cnt + CNT_W'(accept);
  assign enq_head_o   = accept && (ins_pos == '0);
  assign head_task_o  = q_tid[0];
  assign head_time_o  = q_tim[0];
  assign count_o      = count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      enq_err_o <= 1'b0;
      for (int i = 0; i < NUM_TASKS; i++) begin
        q_tid[i] <= '0;
        q_tim[i] <= '0;
      end
    end else begin
      count     <= count_next_o;
      enq_err_o <= enq_valid_i && !accept;
      for (int i = 0; i < NUM_TASKS; i++) begin
        q_tid[i] <= n_tid[i];
        q_tim[i] <= n_tim[i];
      end
    end
  end
endmodule

// File: rtl/rtq_release_ctl.sv
module rtq_release_ctl
  import rtq_pkg::*;
#(
  parameter int TID_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              wake_irq_i,
  input  logic [TID_W-1:0]  head_task_i,
  input  logic [TIME_W-1:0] head_time_i,
  input  logic [CNT_W-1:0]  count_next_i,
  input  logic              enq_head_i,
  output logic              pop_o,
  output hstate_e           state_o,
  output logic              pend_valid_o,
  output logic [TID_W-1:0]  pend_task_o,
  output logic              tmr_load_o,
  output logic [WAKE_W-1:0] tmr_value_o
);
  logic chk, chk_next, expired, irq_ok, arm;
  logic signed [TIME_W-1:0] left;

  assign left     = time_left(head_time_i, now_i);
  assign expired  = (left <= 0);
  assign pop_o    = chk && expired;
  assign arm      = chk && !expired;
  assign irq_ok   = wake_irq_i && (state_o == ST_WAIT);
  assign chk_next = (count_next_i != '0) && (pop_o || enq_head_i || irq_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk          <= 1'b0;
      state_o      <= ST_IDLE;
      pend_valid_o <= 1'b0;
      pend_task_o  <= '0;
      tmr_load_o   <= 1'b0;
      tmr_value_o  <= '0;
    end else begin
      chk          <= chk_next;
      state_o      <= (count_next_i != '0) ? ST_WAIT : ST_IDLE;
      pend_valid_o <= pop_o;
      pend_task_o  <= pop_o ? head_task_i : '0;
      tmr_load_o   <= arm;
      tmr_value_o  <= arm ? wake_reload(left) : '0;
    end
  end
endmodule

// File: rtl/release_timer_queue.sv
module release_timer_queue
  import rtq_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  localparam int TID_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int CNT_W = $clog2(NUM_TASKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [TID_W-1:0]  enq_task,
  input  logic [31:0]       enq_time,
  input  logic [31:0]       now,
  input  logic              wake_irq,
  output logic              pend_valid,
  output logic [TID_W-1:0]  pend_task,
  output logic              tmr_load,
  output logic [23:0]       tmr_value,
  output logic              enq_err
);
  logic              pop, enq_head;
  logic [TID_W-1:0]  head_task;
  logic [TIME_W-1:0] head_time;
  logic [CNT_W-1:0]  count, count_next;
  hstate_e           state;

  rtq_order_queue #(.NUM_TASKS(NUM_TASKS), .TID_W(TID_W), .CNT_W(CNT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .pop_i(pop),
    .enq_valid_i(enq_valid), .enq_task_i(enq_task), .enq_time_i(enq_time),
    .head_task_o(head_task), .head_time_o(head_time),
    .count_o(count), .count_next_o(count_next),
    .enq_head_o(enq_head), .enq_err_o(enq_err)
  );

  rtq_release_ctl #(.TID_W(TID_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .now_i(now), .wake_irq_i(wake_irq),
    .head_task_i(head_task), .head_time_i(head_time),
    .count_next_i(count_next), .enq_head_i(enq_head),
    .pop_o(pop), .state_o(state),
    .pend_valid_o(pend_valid), .pend_task_o(pend_task),
    .tmr_load_o(tmr_load), .tmr_value_o(tmr_value)
  );
endmodule

// File: rtl/release_timer_queue_chk.sv
module release_timer_queue_chk
  import rtq_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       now,
  input logic              wake_irq,
  input logic              enq_valid,
  input logic              enq_err,
  input logic              pend_valid,
  input logic              tmr_load,
  input hstate_e           state,
  input logic [CNT_W-1:0]  count,
  input logic [TIME_W-1:0] head_time
);
  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_valid && tmr_load));

  assert_pend_only_when_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> $past(time_left(head_time, now) <= 0));

  assert_release_shrinks_queue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !$past(enq_valid)) |-> (count == $past(count) - 1'b1));

  assert_idle_irq_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wake_irq) |=> (!pend_valid && !tmr_load));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NUM_TASKS));

  assert_err_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enq_err |-> $past(enq_valid));
endmodule

bind release_timer_queue release_timer_queue_chk #(.NUM_TASKS(NUM_TASKS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .now(now), .wake_irq(wake_irq), .enq_valid(enq_valid),
  .enq_err(enq_err), .pend_valid(pend_valid), .tmr_load(tmr_load), .state(state),
  .count(count), .head_time(head_time)
);

// File: tb/test_release_timer_queue.sv
module test_release_timer_queue;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, wake_irq = 1'b0;
  logic [2:0] enq_task = '0;
  logic [31:0] enq_time = '0, now = '0;
  logic pend_valid, tmr_load, enq_err;
  logic [2:0] pend_task;
  logic [23:0] tmr_value;

  int n_tests = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  release_timer_queue #(.NUM_TASKS(N)) i_release_timer_queue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_task(enq_task),
    .enq_time(enq_time), .now(now), .wake_irq(wake_irq),
    .pend_valid(pend_valid), .pend_task(pend_task), .tmr_load(tmr_load),
    .tmr_value(tmr_value), .enq_err(enq_err)
  );

  // ---------- reference model ----------
  logic [2:0]  m_tid [N];
  logic [31:0] m_tim [N];
  int m_cnt;
  bit m_chk, m_pend, m_load, m_err, m_pop, m_head, m_dup;
  logic [2:0] m_ptid;
  logic [23:0] m_lval;
  logic signed [31:0] m_d;
  int m_j;

  function automatic logic [23:0] exp_reload(input logic signed [31:0] d);
    if (d >= 32'sd16777216) return 24'hFFFFFF;
    return 24'(d - 32'sd1);
  endfunction

  function automatic bit is_later(input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] s;
    s = $signed(a - b);
    return s > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_chk = 0; m_pend = 0; m_load = 0; m_err = 0; m_ptid = '0; m_lval = '0;
    end else begin
      m_pop = 0; m_head = 0; m_pend = 0; m_load = 0; m_err = 0;
      m_head = wake_irq && (m_cnt > 0);  // irq honoured only while waiting
      if (m_chk) begin
        m_d = $signed(m_tim[0] - now);
        if (m_d <= 0) begin
          m_pend = 1; m_ptid = m_tid[0]; m_pop = 1;
          for (int k = 0; k < N - 1; k++) begin m_tid[k] = m_tid[k+1]; m_tim[k] = m_tim[k+1]; end
          m_cnt--;
        end else begin
          m_load = 1; m_lval = exp_reload(m_d);
        end
      end
      if (enq_valid) begin
        m_dup = 0;
        for (int k = 0; k < m_cnt; k++) if (m_tid[k] == enq_task) m_dup = 1;
        if (m_dup || m_cnt == N) m_err = 1;
        else begin
          m_j = m_cnt;
          while (m_j > 0 && is_later(m_tim[m_j-1], enq_time)) begin
            m_tid[m_j] = m_tid[m_j-1]; m_tim[m_j] = m_tim[m_j-1]; m_j--;
          end
          m_tid[m_j] = enq_task; m_tim[m_j] = enq_time; m_cnt++;
          if (m_j == 0) m_head = 1;
        end
      end
      m_chk = (m_cnt > 0) && (m_pop || m_head);
    end
  end

  // ---------- per-cycle comparison and release log ----------
  logic [2:0] log_tid [32];
  int log_n = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      n_tests++;
      if (pend_valid !== m_pend || (m_pend && pend_task !== m_ptid) ||
          tmr_load !== m_load || (m_load && tmr_value !== m_lval) || enq_err !== m_err) begin
        n_fail++;
        $display("FAIL %s cycle: pend %0b/%0d load %0b/%h err %0b, expected pend %0b/%0d load %0b/%h err %0b",
                 cur_req, pend_valid, pend_task, tmr_load, tmr_value, enq_err,
                 m_pend, m_ptid, m_load, m_lval, m_err);
      end
      if (pend_valid && log_n < 32) begin log_tid[log_n] = pend_task; log_n++; end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic drive_enq(input logic [2:0] t, input logic [31:0] tm);
    enq_valid = 1'b1; enq_task = t; enq_time = tm;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic pulse_irq();
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {pend_valid, tmr_load, enq_err}, 3'b000);
    rst_n = 1'b1;
    step();
    check("R1", {pend_valid, tmr_load, enq_err}, 3'b000);
    cmp_en = 1;

    // R3 / R4: expired request pended one cycle after it is evaluated
    cur_req = "R3"; now = 32'd1000;
    drive_enq(3'd1, 32'd990);
    check("R3", pend_valid, 1'b0);
    step();
    check("R3", pend_valid, 1'b1);
    check("R4", pend_task, 3'd1);
    step();
    check("R4", pend_valid, 1'b0);

    // R6: short and long remaining times
    cur_req = "R6";
    drive_enq(3'd2, 32'd1100);
    step();
    check("R6", {tmr_load, tmr_value}, {1'b1, 24'd99});
    drive_enq(3'd3, 32'd1000 + 32'h3000000);
    now = 32'd1100;
    pulse_irq();
    step();
    check("R4", {pend_valid, pend_task}, {1'b1, 3'd2});
    step();
    check("R6", {tmr_load, tmr_value}, {1'b1, 24'hFFFFFF});

    // R5: irq while waiting triggers, irq while idle ignored
    cur_req = "R5"; now = 32'd1000 + 32'h3000000;
    pulse_irq();
    step();
    check("R5", {pend_valid, pend_task}, {1'b1, 3'd3});
    step();
    pulse_irq();
    check("R5", {pend_valid, tmr_load}, 2'b00);
    step();
    check("R5", {pend_valid, tmr_load}, 2'b00);

    // R2: sorted order, ties in arrival order
    cur_req = "R2"; now = 32'd5000;
    drive_enq(3'd5, 32'd6000);
    drive_enq(3'd6, 32'd5500);
    drive_enq(3'd7, 32'd6000);
    drive_enq(3'd0, 32'd5500);
    step(); step();
    now = 32'd7000; log_n = 0;
    pulse_irq();
    repeat (6) step();
    check("R2", log_n, 4);
    check("R2", log_tid[0], 3'd6);
    check("R2", log_tid[1], 3'd0);
    check("R2", log_tid[2], 3'd5);
    check("R2", log_tid[3], 3'd7);

    // R7 / R8: duplicate rejected, full capacity accepted
    cur_req = "R8"; now = 32'd8000;
    drive_enq(3'd4, 32'd9000);
    check("R8", enq_err, 1'b0);
    drive_enq(3'd4, 32'd9500);
    check("R8", enq_err, 1'b1);
    step();
    check("R8", enq_err, 1'b0);
    cur_req = "R7";
    for (int t = 0; t < N; t++) begin
      if (t != 4) begin
        drive_enq(3'(t), 32'd9000 + 32'(t) * 10);
        check("R7", enq_err, 1'b0);
      end
    end
    drive_enq(3'd4, 32'd9999);
    check("R7", enq_err, 1'b1);
    step();
    now = 32'd20000; log_n = 0;
    pulse_irq();
    repeat (10) step();
    check("R7", log_n, N);

    // R9: release and re-request of the same task in one cycle
    cur_req = "R9"; now = 32'd30000;
    drive_enq(3'd1, 32'd30500);
    step();
    now = 32'd30600;
    pulse_irq();
    drive_enq(3'd1, 32'd40000);
    check("R9", {pend_valid, pend_task, enq_err}, {1'b1, 3'd1, 1'b0});
    step();
    check("R9", {tmr_load, tmr_value}, {1'b1, 24'd9399});
    now = 32'd40000;
    pulse_irq();
    step();
    check("R9", {pend_valid, pend_task}, {1'b1, 3'd1});
    step();

    // R10: deadline just past a wrap of the time base
    cur_req = "R10"; now = 32'hFFFF_FF00;
    drive_enq(3'd2, 32'h0000_0010);
    step();
    check("R10", {tmr_load, tmr_value}, {1'b1, 24'd271});
    now = 32'h0000_0020;
    pulse_irq();
    step();
    check("R10", {pend_valid, pend_task}, {1'b1, 3'd2});

    // constrained random phase, judged by the model each cycle
    cur_req = "R4/R6 random";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 63) == 0) now = now + $urandom_range(0, 32'h100_0000);
      else now = now + $urandom_range(0, 40);
      wake_irq = ($urandom_range(0, 5) == 0);
      enq_valid = ($urandom_range(0, 2) == 0);
      enq_task = 3'($urandom_range(0, N - 1));
      if ($urandom_range(0, 7) == 0) enq_time = now + $urandom_range(0, 32'h200_0000);
      else enq_time = now + $urandom_range(0, 4000) - 32'd500;
      @(negedge clk);
    end
    enq_valid = 1'b0; wake_irq = 1'b0;
    repeat (4) step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule